// File: doc/BRIEF.md
# Read-to-Write Bus Turnaround Scheduler

This block sits between a controller's command queue and a synchronous DRAM interface. It issues reads straight away. When a write arrives while read data may still be coming back on the shared data bus, it delays that write. If the read is still far from done, it raises the byte-mask lines to stop the remaining read words from being driven.

The memory applies its masks to read data two cycles after it samples them, whatever the CAS latency (1, 2 or 3). The block combines that fixed latency with the selected CAS latency and the time left in the current read. From these it picks one of two plans:

- **Wait it out:** let the read finish, then keep one empty cycle before the write.
- **Cut it short:** assert the masks for three cycles and issue the write in the third cycle after the request.

In both cases the cycle just before the write is left undriven by both sides. A read issued with auto-precharge cannot be cut short, so a write behind it always waits for the read to finish.

The controller enables its data-bus drivers only in the write command cycle and during the rest of that write's data beats. During those beats the masks carry the per-lane write mask taken from the queue. At all other times the masks are low, except while read data is being suppressed.

Top module: `rwturn_sched`

## Requirements
- R1: A read request (kind code 1) presented while the block is ready is issued as command code 1 in the same cycle, with the auto-precharge flag copied to `cmd_ap_o`. The memory drives its words in cycles t+CL through t+CL+BURST-1, where t is the issue cycle and CL is the CAS latency.
- R2: A write (kind 2) or block write (kind 3) accepted in cycle n, behind a read whose last word falls in cycle L, is issued in cycle max(n, L+2) whenever L ≤ n+1. No masks are raised, and cycle L+1 is left with no driver on the bus.
- R3: If the read has no auto-precharge and L > n+1, the masks are all high in cycles n, n+1 and n+2, and the write is issued in cycle n+3. That read's words from cycle n+2 onward never reach the bus.
- R4: Behind a read with auto-precharge, a write accepted in cycle n is issued in cycle max(n, L+2) and the masks stay low, even when L > n+1.
- R5: `dq_oe_o` is high in the write command cycle and the following BURST-1 cycles. For a block write it is high only in the command cycle. It is never high in the guard cycle before a write.
- R6: During a write's data beats the masks equal the request's `req_mask` (bit set = lane masked). Outside the data beats and the suppression window, the masks are low.
- R7: While a write is being held back, the issued command is NOP (code 0) and `req_ready` is low. `req_ready` returns high in the cycle after the write is issued.
- R8: A read issued during a write's data beats ends the controller's drive: `dq_oe_o` is low from the following cycle.
- R9: No cycle has both the memory driving read data (a word inside a read window, not masked two cycles earlier, and not cut off by a later write) and `dq_oe_o` high.
- R10: While `rst` is high, the command is NOP, `req_ready`, `dq_oe_o` and the masks are low, and no request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cas_lat | input | 2 | Selected CAS latency, 1 to 3 |
| req_valid | input | 1 | Queue head holds a command |
| req_kind | input | 2 | 0 none, 1 read, 2 write, 3 block write |
| req_ap | input | 1 | Auto-precharge requested with the command |
| req_mask | input | LANES | Per-lane write mask, 1 = lane not written |
| req_ready | output | 1 | Head command is taken this cycle |
| cmd_o | output | 2 | Issued command, same code as req_kind (0 = NOP) |
| cmd_ap_o | output | 1 | Auto-precharge flag of the issued command |
| dqm_o | output | LANES | Byte-mask lines to the memory |
| dq_oe_o | output | 1 | Controller data-bus drive enable |

## Verification
Reads, and writes that need no wait, appear on `cmd_o` in the same cycle the request is accepted, because the issue path is combinational from state and request. A delayed write appears exactly as many cycles after acceptance as its computed wait. A mask raised in cycle m takes effect on read data in cycle m+2. The bench drives each cycle's inputs at the falling edge and samples outputs 1 ns later, so every recorded value belongs to one known cycle index. It sweeps CAS latency, request gap and auto-precharge. For each case it computes the wait and the expected mask, command, enable and ready pattern, and builds a memory drive model from the recorded ports that includes the two-cycle mask latency, to check the guard cycle and the absence of overlap.

// File: rtl/rwturn_pkg.sv
package rwturn_pkg;

    localparam int TAIL_W    = 8;
    localparam int DQM_LAT   = 2;
    localparam int GUARD_CYC = 1;
    localparam int CUT_WAIT  = DQM_LAT + GUARD_CYC;

    typedef enum logic [1:0] {
        CMD_NOP    = 2'd0,
        CMD_READ   = 2'd1,
        CMD_WRITE  = 2'd2,
        CMD_BWRITE = 2'd3
    } cmd_e;

    typedef struct packed {
        logic [TAIL_W-1:0] wait_cyc;
        logic              suppress;
    } plan_t;

    function automatic logic is_wr(input cmd_e c);
        return (c == CMD_WRITE) || (c == CMD_BWRITE);
    endfunction

    // tail = cycles until a write could go out with no masking at all
    function automatic plan_t plan_write(input logic [TAIL_W-1:0] tail,
                                         input logic ap_locked);
        plan_t p;
        p.wait_cyc = tail;
        p.suppress = 1'b0;
        if (!ap_locked && (tail > TAIL_W'(CUT_WAIT))) begin
            p.wait_cyc = TAIL_W'(CUT_WAIT);
            p.suppress = 1'b1;
        end
        return p;
    endfunction

endpackage

// File: rtl/rwturn_rdtrack.sv
module rwturn_rdtrack
    import rwturn_pkg::*;
#(
    parameter int BURST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_issue,
    input  logic              wr_issue,
    input  logic              rd_ap,
    input  logic [1:0]        cas_lat,
    output logic [TAIL_W-1:0] tail,
    output logic              ap_locked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tail      <= '0;
            ap_locked <= 1'b0;
        end else if (rd_issue) begin
            tail      <= TAIL_W'(cas_lat) + TAIL_W'(BURST);
            ap_locked <= rd_ap;
        end else if (wr_issue) begin
            tail      <= '0;
            ap_locked <= 1'b0;
        end else if (tail != '0) begin
            tail <= tail - 1'b1;
        end
    end

    // R2
    property tail_drain_p;
        @(posedge clk) disable iff (rst)
        !rd_issue |=> (tail <= $past(tail));
    endproperty
    tail_drain_chk: assert property (tail_drain_p);

endmodule

// File: rtl/rwturn_wrphase.sv
module rwturn_wrphase #(
    parameter int LANES = 4,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_issue,
    input  logic             bw_issue,
    input  logic             rd_issue,
    input  logic [LANES-1:0] wmask,
    output logic             oe,
    output logic [LANES-1:0] wr_dqm
);

    localparam int CW = $clog2(BURST + 1);

    logic [CW-1:0]    left;
    logic [LANES-1:0] mreg;
    logic             start;

    assign start = wr_issue | bw_issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            left <= '0;
            mreg <= '0;
        end else if (wr_issue) begin
            left <= CW'(BURST - 1);
            mreg <= wmask;
        end else if (bw_issue) begin
            left <= '0;
            mreg <= wmask;
        end else if (rd_issue) begin
            left <= '0;
        end else if (left != '0) begin
            left <= left - 1'b1;
        end
    end

    assign oe = start | (left != '0);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign wr_dqm[i] = start ? wmask[i] : mreg[i];
    end

    // R5
    property oe_source_p;
        @(posedge clk) disable iff (rst)
        $rose(oe) |-> start;
    endproperty
    oe_source_chk: assert property (oe_source_p);

endmodule

// File: rtl/rwturn_sched.sv
module rwturn_sched
    import rwturn_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       cas_lat,
    input  logic             req_valid,
    input  logic [1:0]       req_kind,
    input  logic             req_ap,
    input  logic [LANES-1:0] req_mask,
    output logic             req_ready,
    output logic [1:0]       cmd_o,
    output logic             cmd_ap_o,
    output logic [LANES-1:0] dqm_o,
    output logic             dq_oe_o
);

    typedef enum logic {ST_IDLE, ST_HOLD} st_e;

    st_e               st;
    logic [TAIL_W-1:0] cnt;
    cmd_e              pend_kind;
    logic              pend_ap;
    logic              pend_sup;
    logic [LANES-1:0]  pend_mask;

    logic [TAIL_W-1:0] tail;
    logic              ap_locked;
    plan_t             plan;
    cmd_e              req_cmd;
    cmd_e              issue;
    logic              take;
    logic              issue_ap;
    logic              sup_now;
    logic [LANES-1:0]  issue_mask;
    logic              ph_oe;
    logic [LANES-1:0]  ph_dqm;

    assign req_cmd = cmd_e'(req_kind);
    assign take    = !rst && (st == ST_IDLE) && req_valid && (req_cmd != CMD_NOP);
    assign plan    = plan_write(tail, ap_locked);

    always_comb begin
        issue      = CMD_NOP;
        issue_ap   = 1'b0;
        sup_now    = 1'b0;
        issue_mask = req_mask;
        if (st == ST_IDLE) begin
            if (take) begin
                if (req_cmd == CMD_READ) begin
                    issue    = CMD_READ;
                    issue_ap = req_ap;
                end else if (plan.wait_cyc == '0) begin
                    issue    = req_cmd;
                    issue_ap = req_ap;
                end else begin
                    sup_now = plan.suppress;
                end
            end
        end else begin
            issue_mask = pend_mask;
            if (cnt == '0) begin
                issue    = pend_kind;
                issue_ap = pend_ap;
            end else begin
                sup_now = pend_sup;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            cnt       <= '0;
            pend_kind <= CMD_NOP;
            pend_ap   <= 1'b0;
            pend_sup  <= 1'b0;
            pend_mask <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (take && is_wr(req_cmd) && (plan.wait_cyc != '0)) begin
                        st        <= ST_HOLD;
                        cnt       <= plan.wait_cyc - 1'b1;
                        pend_kind <= req_cmd;
                        pend_ap   <= req_ap;
                        pend_sup  <= plan.suppress;
                        pend_mask <= req_mask;
                    end
                end
                default: begin
                    if (cnt == '0) st  <= ST_IDLE;
                    else           cnt <= cnt - 1'b1;
                end
            endcase
        end
    end

    rwturn_rdtrack #(.BURST(BURST)) u_rdtrack (
        .clk       (clk),
        .rst       (rst),
        .rd_issue  (issue == CMD_READ),
        .wr_issue  (is_wr(issue)),
        .rd_ap     (issue_ap),
        .cas_lat   (cas_lat),
        .tail      (tail),
        .ap_locked (ap_locked)
    );

    rwturn_wrphase #(.LANES(LANES), .BURST(BURST)) u_wrphase (
        .clk      (clk),
        .rst      (rst),
        .wr_issue (issue == CMD_WRITE),
        .bw_issue (issue == CMD_BWRITE),
        .rd_issue (issue == CMD_READ),
        .wmask    (issue_mask),
        .oe       (ph_oe),
        .wr_dqm   (ph_dqm)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_dqm
        assign dqm_o[i] = sup_now | (ph_oe & ph_dqm[i]);
    end

    assign cmd_o     = issue;
    assign cmd_ap_o  = issue_ap;
    assign dq_oe_o   = ph_oe;
    assign req_ready = !rst && (st == ST_IDLE);

    // R3
    property mask_lead_p;
        @(posedge clk) disable iff (rst)
        (is_wr(issue) && $past(sup_now)) |->
            ($past(dqm_o, 2) == {LANES{1'b1}}) && ($past(dqm_o, 3) == {LANES{1'b1}});
    endproperty
    mask_lead_chk: assert property (mask_lead_p);

    // R2
    property guard_p;
        @(posedge clk) disable iff (rst)
        (is_wr(issue) && !$past(sup_now)) |-> (tail == '0);
    endproperty
    guard_chk: assert property (guard_p);

    // R8
    property rd_cut_p;
        @(posedge clk) disable iff (rst)
        (issue == CMD_READ) |=> !dq_oe_o;
    endproperty
    rd_cut_chk: assert property (rd_cut_p);

    // R7
    property hold_p;
        @(posedge clk) disable iff (rst)
        (st == ST_HOLD && cnt != '0) |-> (cmd_o == 2'd0) && !req_ready && !dq_oe_o;
    endproperty
    hold_chk: assert property (hold_p);

endmodule

// File: tb/rwturn_sched_test.sv
module rwturn_sched_test;

    localparam int LANES = 4;
    localparam int BURST = 4;
    localparam int NC    = 24;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       cas_lat = 2'd2;
    logic             req_valid = 1'b0;
    logic [1:0]       req_kind = 2'd0;
    logic             req_ap = 1'b0;
    logic [LANES-1:0] req_mask = '0;
    logic             req_ready;
    logic [1:0]       cmd_o;
    logic             cmd_ap_o;
    logic [LANES-1:0] dqm_o;
    logic             dq_oe_o;

    rwturn_sched #(.LANES(LANES), .BURST(BURST)) uut (
        .clk(clk), .rst(rst), .cas_lat(cas_lat), .req_valid(req_valid),
        .req_kind(req_kind), .req_ap(req_ap), .req_mask(req_mask),
        .req_ready(req_ready), .cmd_o(cmd_o), .cmd_ap_o(cmd_ap_o),
        .dqm_o(dqm_o), .dq_oe_o(dq_oe_o)
    );

    always #2 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    logic [1:0]       lc [NC];
    logic [LANES-1:0] lm [NC];
    logic             lo [NC];
    logic             lr [NC];
    logic             la [NC];
    logic             mem[NC];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'd0; req_ap = 1'b0; req_mask = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    // memory drive model built from recorded ports; dqm acts two cycles later
    task automatic predict_mem(input int cl);
        for (int c = 0; c < NC; c++) mem[c] = 1'b0;
        for (int r = 0; r < NC; r++) begin
            if (lc[r] == 2'd1) begin
                for (int k = 0; k < BURST; k++) begin
                    int  c = r + cl + k;
                    bit  cut = 1'b0;
                    if (c < NC) begin
                        for (int q = r + 1; q <= c; q++)
                            if (lc[q] >= 2'd1) cut = 1'b1;
                        if (!cut && !(c >= 2 && lm[c-2] == {LANES{1'b1}}))
                            mem[c] = 1'b1;
                    end
                end
            end
        end
    endtask

    task automatic run_scn(input int cl, input int g, input bit ap,
                           input logic [1:0] wk, input logic [LANES-1:0] wm);
        bit acc = 1'b0;
        int tail, wt, w, nb, bad;
        bit sup;
        string tag;
        do_reset();
        cas_lat = 2'(cl);
        for (int c = 0; c < NC; c++) begin
            if (c > 0) @(negedge clk);
            if (c == 0) begin
                req_valid = 1'b1; req_kind = 2'd1; req_ap = ap; req_mask = '0;
            end else if (c >= g && !acc) begin
                req_valid = 1'b1; req_kind = wk; req_ap = 1'b0; req_mask = wm;
            end else begin
                req_valid = 1'b0; req_kind = 2'd0; req_ap = 1'b0; req_mask = '0;
            end
            #1;
            lc[c] = cmd_o; lm[c] = dqm_o; lo[c] = dq_oe_o; lr[c] = req_ready; la[c] = cmd_ap_o;
            if (c >= g && req_valid && req_ready) acc = 1'b1;
        end
        req_valid = 1'b0;

        tail = cl + BURST + 1 - g;
        if (tail < 0) tail = 0;
        sup = !ap && (tail > 3);
        wt  = ap ? tail : (sup ? 3 : tail);
        w   = g + wt;
        nb  = (wk == 2'd3) ? 1 : BURST;
        tag = ap ? "R4" : (sup ? "R3" : "R2");

        // R1: read issued at once with its flag
        chk(lc[0] == 2'd1 && la[0] == ap, "R1", "read issue/ap at cycle 0",
            int'({lc[0], la[0]}), int'({2'd1, ap}));

        bad = -1;
        for (int c = 0; c < NC; c++) begin
            logic [1:0] e = (c == 0) ? 2'd1 : ((c == w) ? wk : 2'd0);
            if (lc[c] != e && bad < 0) bad = c;
        end
        chk(bad < 0, tag, $sformatf("cmd cl=%0d gap=%0d ap=%0d at cycle %0d", cl, g, ap, bad),
            (bad < 0) ? 0 : int'(lc[bad]), (bad == w) ? int'(wk) : 0);

        bad = -1;
        for (int c = 0; c < NC; c++) begin
            logic [LANES-1:0] e = '0;
            if (sup && c >= g && c <= g + 2) e = {LANES{1'b1}};
            else if (c >= w && c < w + nb) e = wm;
            if (lm[c] != e && bad < 0) bad = c;
        end
        chk(bad < 0, sup ? "R3" : "R6", $sformatf("dqm cl=%0d gap=%0d at cycle %0d", cl, g, bad),
            (bad < 0) ? 0 : int'(lm[bad]), int'(wm));

        bad = -1;
        for (int c = 0; c < NC; c++)
            if (lo[c] != (c >= w && c < w + nb) && bad < 0) bad = c;
        chk(bad < 0, "R5", $sformatf("oe cl=%0d gap=%0d at cycle %0d", cl, g, bad),
            (bad < 0) ? 0 : int'(lo[bad]), (bad >= w && bad < w + nb) ? 1 : 0);

        bad = -1;
        for (int c = 0; c < NC; c++)
            if (lr[c] != !(c > g && c <= w) && bad < 0) bad = c;
        chk(bad < 0, "R7", $sformatf("ready cl=%0d gap=%0d at cycle %0d", cl, g, bad),
            (bad < 0) ? 0 : int'(lr[bad]), (bad > g && bad <= w) ? 0 : 1);

        predict_mem(cl);
        bad = -1;
        for (int c = 0; c < NC; c++)
            if (mem[c] && lo[c] && bad < 0) bad = c;
        chk(bad < 0, "R9", $sformatf("bus overlap cl=%0d gap=%0d at cycle", cl, g), bad, -1);
        chk(!mem[w-1] && !lo[w-1], "R2", $sformatf("guard cycle %0d cl=%0d gap=%0d", w - 1, cl, g),
            int'({mem[w-1], lo[w-1]}), 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        // R10: reset holds everything quiet even with a request waiting
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b1; req_kind = 2'd2; req_mask = 4'h3;
        #1;
        chk(cmd_o == 2'd0, "R10", "cmd in reset", int'(cmd_o), 0);
        chk(!req_ready && !dq_oe_o && dqm_o == '0, "R10", "ready/oe/dqm in reset",
            int'({req_ready, dq_oe_o, dqm_o}), 0);
        req_valid = 1'b0;

        for (int cl = 1; cl <= 3; cl++)
            for (int g = 1; g <= 9; g++)
                for (int ap = 0; ap <= 1; ap++)
                    run_scn(cl, g, ap[0], 2'd2, LANES'((g * 3 + cl) & 15));
        for (int g = 1; g <= 9; g++)
            run_scn(2, g, 1'b0, 2'd3, LANES'(g & 15));

        // R8: read during write beats stops the controller drive next cycle
        do_reset();
        cas_lat = 2'd2;
        for (int c = 0; c < 6; c++) begin
            if (c > 0) @(negedge clk);
            req_valid = (c == 0) || (c == 2);
            req_kind  = (c == 0) ? 2'd2 : ((c == 2) ? 2'd1 : 2'd0);
            req_mask  = 4'h5;
            #1;
            lo[c] = dq_oe_o; lc[c] = cmd_o; lm[c] = dqm_o;
        end
        req_valid = 1'b0;
        chk(lc[0] == 2'd2 && lc[2] == 2'd1, "R8", "write then read commands",
            int'({lc[0], lc[2]}), int'({2'd2, 2'd1}));
        chk(lo[0] && lo[1] && lo[2], "R8", "oe before cut", int'({lo[0], lo[1], lo[2]}), 7);
        chk(!lo[3] && !lo[4] && !lo[5], "R8", "oe after cut", int'({lo[3], lo[4], lo[5]}), 0);
        chk(lm[1] == 4'h5 && lm[3] == 4'h0, "R6", "mask during and after beats",
            int'({lm[1], lm[3]}), int'({4'h5, 4'h0}));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule